// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers single-cycle event pulses from a fixed number of interrupt sources and latches each one into a sticky pending flag. Every cycle it selects the most urgent source that is allowed to interrupt the processor. It then presents a request line and that source's vector number. A source is allowed when all of the following hold:

- all three of its enables are set;
- it is not masked by the priority threshold;
- it is strictly more urgent than the handler currently running.

When the processor takes the interrupt it pulses an entry acknowledge, and the controller pushes the taken priority onto an internal stack of active levels. A return strobe pops that stack. Nesting is therefore allowed only for strictly more urgent sources, and a source whose flag software did not clear asks again as soon as its level is no longer blocked.

Configuration goes through a plain register-write port (strobe, address, data). The address map is: 0 local enable mask, 1 controller enable mask, 2 global enable (bit 0), 3 threshold, 4 clear pending (write-one-to-clear mask), 5 priority (bits 2:0 priority value, bits 10:8 source index). The request, vector, acknowledge and return pins are plain control pins with no back-pressure. The processor acknowledges the vector shown in the same cycle.

Top module: `nprio_irq_ctrl`

## Requirements
- R1: A pulse on a source's event input sets its pending flag, which stays set until a write to address 4 with that source's bit at 1; an event and a clear on the same source in the same cycle leave the flag set.
- R2: A source can request only when its bit in the local enable mask (address 0), its bit in the controller enable mask (address 1) and the global enable (address 2 bit 0) are all 1.
- R3: A lower priority value is more urgent; among eligible sources the lowest value wins, and a tie goes to the lowest source index.
- R4: A source can request only if its priority value is strictly below that of the top of the active stack (any value when the stack is empty); an equal value never preempts.
- R5: With a nonzero threshold T (address 3), sources whose priority value is T or greater are masked; a threshold of 0 masks nothing.
- R6: While the request is high, the vector output equals VEC_BASE plus the index of the selected source.
- R7: An acknowledge while the request is high pushes the presented priority onto the active stack and drops the request at that same edge; a return strobe pops the top entry; a return with an empty stack is ignored.
- R8: After a return, a source whose pending flag is still set and which is now eligible requests again at the next edge.
- R9: Arbitration is registered: an event, register write or return sampled at clock edge E shows on the request and vector outputs after edge E+1.
- R10: After reset the request is low, the stack is empty, all pending flags, enables and the threshold are 0, and every priority is the least urgent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NSRC | Event pulses, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | DATA_W | Register write data |
| ack_i | input | 1 | Processor entry acknowledge |
| eoi_i | input | 1 | Processor return strobe |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | VEC_W | Vector number of the requesting source |

## Verification
Inputs sampled at edge E change pending flags, configuration and the active stack at E. The request and vector built from that state appear after E+1. The one exception is the acknowledge, which clears the request at E itself.

The bench drives inputs on the falling edge and checks outputs one time unit after each rising edge. Its reference model computes the expected request at each edge from the model state that held before that edge, and only then applies the edge's updates. The model is therefore exactly one register behind the state in the same way the design is, and every cycle is compared.

// File: rtl/nprio_pkg.sv
package nprio_pkg;

  // register addresses of the configuration port
  typedef enum logic [2:0] {
    REG_LEN = 3'd0,
    REG_CEN = 3'd1,
    REG_GEN = 3'd2,
    REG_THR = 3'd3,
    REG_CLR = 3'd4,
    REG_PRI = 3'd5
  } reg_sel_e;

  // bit position of the source index in a priority write
  localparam int PRI_SRC_LSB = 8;

endpackage

// File: rtl/nprio_cfg.sv
module nprio_cfg
  import nprio_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NSRC-1:0]          loc_en,
  output logic [NSRC-1:0]          ctl_en,
  output logic                     glb_en,
  output logic [PRIO_W-1:0]        thr,
  output logic [NSRC-1:0]          clr_mask,
  output logic [NSRC*PRIO_W-1:0]   prio_flat
);

  localparam logic [PRIO_W-1:0] LEAST = '1;

  logic unused_data;
  assign unused_data = ^wr_data;

  logic sel_len, sel_cen, sel_gen, sel_thr, sel_clr, sel_pri;
  assign sel_len = wr_en && (wr_addr == REG_LEN);
  assign sel_cen = wr_en && (wr_addr == REG_CEN);
  assign sel_gen = wr_en && (wr_addr == REG_GEN);
  assign sel_thr = wr_en && (wr_addr == REG_THR);
  assign sel_clr = wr_en && (wr_addr == REG_CLR);
  assign sel_pri = wr_en && (wr_addr == REG_PRI);

  assign clr_mask = sel_clr ? wr_data[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_en <= '0;
      ctl_en <= '0;
      glb_en <= 1'b0;
      thr    <= '0;
    end else begin
      if (sel_len) loc_en <= wr_data[NSRC-1:0];
      if (sel_cen) ctl_en <= wr_data[NSRC-1:0];
      if (sel_gen) glb_en <= wr_data[0];
      if (sel_thr) thr    <= wr_data[PRIO_W-1:0];
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_prio
    logic hit;
    assign hit = sel_pri && (wr_data[PRI_SRC_LSB +: SRC_W] == SRC_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio_flat[s*PRIO_W +: PRIO_W] <= LEAST;
      else if (hit) prio_flat[s*PRIO_W +: PRIO_W] <= wr_data[PRIO_W-1:0];
    end
  end

endmodule

// File: rtl/nprio_pend.sv
module nprio_pend #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | evt;
  end

endmodule

// File: rtl/nprio_stack.sv
module nprio_stack #(
  parameter int PRIO_W = 3,
  parameter int LEVELS = 8,
  parameter int DEP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [DEP_W-1:0]  depth,
  output logic [PRIO_W-1:0] top_prio,
  output logic [PRIO_W:0]   run_lvl
);

  logic [PRIO_W-1:0] stk [LEVELS];
  logic pop_eff, push_eff;

  assign pop_eff  = pop && (depth != '0);
  assign push_eff = push && (pop_eff || (depth < DEP_W'(LEVELS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth <= '0;
    else if (push_eff && !pop_eff) depth <= depth + DEP_W'(1);
    else if (pop_eff && !push_eff) depth <= depth - DEP_W'(1);
  end

  for (genvar e = 0; e < LEVELS; e++) begin : g_ent
    logic wr_here;
    // plain push writes the free slot; pop+push overwrites the top slot
    assign wr_here = push_eff &&
                     ((!pop_eff && depth == DEP_W'(e)) ||
                      ( pop_eff && depth == DEP_W'(e + 1)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stk[e] <= '0;
      else if (wr_here) stk[e] <= push_prio;
    end
  end

  always_comb begin
    top_prio = '0;
    for (int e = 0; e < LEVELS; e++) begin
      if (depth == DEP_W'(e + 1)) top_prio = stk[e];
    end
  end

  assign run_lvl = (depth == '0) ? (PRIO_W+1)'(LEVELS) : {1'b0, top_prio};

endmodule

// File: rtl/nprio_arb.sv
module nprio_arb #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int SRC_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC-1:0]        loc_en,
  input  logic [NSRC-1:0]        ctl_en,
  input  logic                   glb_en,
  input  logic [PRIO_W-1:0]      thr,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W:0]        run_lvl,
  input  logic                   ack,
  output logic                   req,
  output logic [SRC_W-1:0]       src,
  output logic [PRIO_W-1:0]      req_prio
);

  logic              found;
  logic [SRC_W-1:0]  best_src;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    found    = 1'b0;
    best_src = '0;
    best_p   = '0;
    // scan downwards so that a tie settles on the lowest index
    for (int i = NSRC - 1; i >= 0; i--) begin
      logic [PRIO_W-1:0] p;
      logic ok;
      p  = prio_flat[i*PRIO_W +: PRIO_W];
      ok = pend[i] && loc_en[i] && ctl_en[i] && glb_en &&
           ((thr == '0) || (p < thr)) &&
           ({1'b0, p} < run_lvl);
      if (ok && (!found || p <= best_p)) begin
        found    = 1'b1;
        best_src = SRC_W'(i);
        best_p   = p;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req      <= 1'b0;
      src      <= '0;
      req_prio <= '0;
    end else if (ack) begin
      req      <= 1'b0;
    end else begin
      req      <= found;
      src      <= best_src;
      req_prio <= best_p;
    end
  end

endmodule

// File: rtl/nprio_irq_ctrl.sv
module nprio_irq_ctrl #(
  parameter int NSRC     = 8,
  parameter int PRIO_W   = 3,
  parameter int DATA_W   = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o
);

  localparam int SRC_W  = $clog2(NSRC);
  localparam int LEVELS = 1 << PRIO_W;
  localparam int DEP_W  = PRIO_W + 1;

  logic [NSRC-1:0]        loc_en, ctl_en, clr_mask, pend;
  logic                   glb_en;
  logic [PRIO_W-1:0]      thr, top_prio, req_prio;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [DEP_W-1:0]       stk_depth;
  logic [PRIO_W:0]        run_lvl;
  logic [SRC_W-1:0]       req_src;

  nprio_cfg #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .SRC_W(SRC_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .loc_en(loc_en), .ctl_en(ctl_en), .glb_en(glb_en),
    .thr(thr), .clr_mask(clr_mask), .prio_flat(prio_flat)
  );

  nprio_pend #(.NSRC(NSRC)) pend_i (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(clr_mask), .pend(pend)
  );

  nprio_stack #(.PRIO_W(PRIO_W), .LEVELS(LEVELS), .DEP_W(DEP_W)) stack_i (
    .clk(clk), .rst_n(rst_n), .push(ack_i && irq_req_o), .pop(eoi_i),
    .push_prio(req_prio), .depth(stk_depth), .top_prio(top_prio),
    .run_lvl(run_lvl)
  );

  nprio_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .pend(pend), .loc_en(loc_en), .ctl_en(ctl_en),
    .glb_en(glb_en), .thr(thr), .prio_flat(prio_flat), .run_lvl(run_lvl),
    .ack(ack_i), .req(irq_req_o), .src(req_src), .req_prio(req_prio)
  );

  assign irq_vec_o = VEC_W'(VEC_BASE) + VEC_W'(req_src);

endmodule

// File: rtl/nprio_chk.sv
module nprio_chk #(
  parameter int NSRC     = 8,
  parameter int PRIO_W   = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int DEP_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec,
  input logic              ack,
  input logic              eoi,
  input logic [DEP_W-1:0]  depth,
  input logic [PRIO_W-1:0] top_prio,
  input logic [PRIO_W-1:0] req_prio
);

  localparam int LEVELS = 1 << PRIO_W;

  assert_ack_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_req);

  assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(irq_vec) >= VEC_BASE && int'(irq_vec) < VEC_BASE + NSRC));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= LEVELS);

  assert_idle_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && depth == '0) |=> depth == '0);

  assert_push_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !eoi && int'(depth) < LEVELS) |=> depth == $past(depth) + DEP_W'(1));

  assert_strict_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !eoi && depth != '0) |-> req_prio < top_prio);

endmodule

bind nprio_irq_ctrl nprio_chk #(
  .NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .DEP_W(DEP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req_o), .irq_vec(irq_vec_o),
  .ack(ack_i), .eoi(eoi_i), .depth(stk_depth), .top_prio(top_prio),
  .req_prio(req_prio)
);

// File: tb/nprio_irq_ctrl_tb.sv
module nprio_irq_ctrl_tb_top;

  localparam int CLK_P    = 10;
  localparam int NSRC     = 8;
  localparam int PRIO_W   = 3;
  localparam int DATA_W   = 16;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 16;
  localparam int LEVELS   = 1 << PRIO_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0]   evt_i = '0;
  logic              wr_en_i = 1'b0;
  logic [2:0]        wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              ack_i = 1'b0;
  logic              eoi_i = 1'b0;
  logic              irq_req_o;
  logic [VEC_W-1:0]  irq_vec_o;

  always #(CLK_P/2) clk = ~clk;

  nprio_irq_ctrl #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
                   .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
    .eoi_i(eoi_i), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R10";

  // reference model state
  bit [NSRC-1:0] m_pend = '0, m_le = '0, m_ce = '0;
  bit m_ge = 0;
  int m_thr = 0;
  int m_prio [NSRC];
  int m_stk [LEVELS];
  int m_dep = 0;
  bit exp_req = 0;
  int exp_src = 0;
  int exp_prio = 0;

  function automatic int pick();
    int best = -1;
    int bp = 0;
    int run = (m_dep == 0) ? LEVELS : m_stk[m_dep-1];
    for (int i = 0; i < NSRC; i++) begin
      if (m_pend[i] && m_le[i] && m_ce[i] && m_ge &&
          (m_thr == 0 || m_prio[i] < m_thr) && m_prio[i] < run &&
          (best < 0 || m_prio[i] < bp)) begin
        best = i;
        bp = m_prio[i];
      end
    end
    return best;
  endfunction

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // one clock: inputs are already set; update model, wait, compare
  task automatic cyc();
    int w = pick();
    bit ack_eff = ack_i && exp_req;
    if (eoi_i && m_dep > 0) m_dep--;
    if (ack_eff) begin
      m_stk[m_dep] = exp_prio;
      m_dep++;
    end
    if (ack_i) exp_req = 0;
    else begin
      exp_req = (w >= 0);
      if (w >= 0) begin
        exp_src = w;
        exp_prio = m_prio[w];
      end
    end
    if (wr_en_i) begin
      case (wr_addr_i)
        3'd0: m_le = wr_data_i[NSRC-1:0];
        3'd1: m_ce = wr_data_i[NSRC-1:0];
        3'd2: m_ge = wr_data_i[0];
        3'd3: m_thr = int'(wr_data_i[PRIO_W-1:0]);
        3'd4: m_pend = m_pend & ~wr_data_i[NSRC-1:0];
        3'd5: m_prio[wr_data_i[10:8]] = int'(wr_data_i[PRIO_W-1:0]);
        default: ;
      endcase
    end
    m_pend = m_pend | evt_i;
    @(posedge clk);
    #1;
    chk({tag, " req"}, int'(irq_req_o), int'(exp_req));
    if (exp_req) chk({tag, " vec"}, int'(irq_vec_o), VEC_BASE + exp_src);
    @(negedge clk);
    evt_i = '0; wr_en_i = 0; ack_i = 0; eoi_i = 0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1; wr_addr_i = 3'(a); wr_data_i = DATA_W'(d); cyc();
  endtask
  task automatic ev(input int m);
    evt_i = NSRC'(m); cyc();
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask
  task automatic do_ack();
    ack_i = 1; cyc();
  endtask
  task automatic do_eoi();
    eoi_i = 1; cyc();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < NSRC; i++) m_prio[i] = LEVELS - 1;
    for (int i = 0; i < LEVELS; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10";
    idle(1);
    chk("R10 reset req", int'(irq_req_o), 0);

    // R2: all three enables needed; R9: one extra clock of latency
    tag = "R2";
    wr(0, 'hFF); wr(1, 'hFF); ev(1 << 2); idle(2);
    chk("R2 global off", int'(irq_req_o), 0);
    tag = "R9";
    wr(2, 1);
    chk("R9 not yet", int'(irq_req_o), 0);
    idle(1);
    chk("R9 one clock later", int'(irq_req_o), 1);
    chk("R6 vector src2", int'(irq_vec_o), 18);
    tag = "R2";
    wr(1, 'hFB); idle(1);
    chk("R2 ctl enable off", int'(irq_req_o), 0);
    wr(1, 'hFF); idle(2);

    // R1: sticky, cleared only by write, event beats clear
    tag = "R1";
    chk("R1 sticky", int'(irq_req_o), 1);
    wr(4, 4); idle(1);
    chk("R1 cleared", int'(irq_req_o), 0);
    evt_i = 4; wr(4, 4); idle(1);
    chk("R1 event wins clear", int'(irq_req_o), 1);
    wr(4, 'hFF); idle(1);

    // R3: priority order and tie break
    tag = "R3";
    wr(5, (1 << 8) | 4); wr(5, (5 << 8) | 4);
    ev((1 << 1) | (1 << 5)); idle(1);
    chk("R3 tie lowest index", int'(irq_vec_o), 17);
    wr(5, (6 << 8) | 1); ev(1 << 6); idle(1);
    chk("R3 lowest value", int'(irq_vec_o), 22);
    wr(4, 'hFF); idle(1);

    // R5: threshold masking
    tag = "R5";
    wr(3, 4); ev(1 << 1); idle(2);
    chk("R5 masked at threshold", int'(irq_req_o), 0);
    wr(3, 5); idle(1);
    chk("R5 below threshold", int'(irq_vec_o), 17);
    wr(3, 0); idle(1);
    chk("R5 zero threshold", int'(irq_req_o), 1);

    // R4, R7, R8: nesting, equal level, return
    tag = "R7";
    do_ack();
    chk("R7 ack drops req", int'(irq_req_o), 0);
    tag = "R4";
    ev(1 << 5); idle(2);
    chk("R4 equal no preempt", int'(irq_req_o), 0);
    wr(5, (5 << 8) | 2); idle(1);
    chk("R4 higher preempts", int'(irq_vec_o), 21);
    do_ack(); idle(1);
    tag = "R8";
    do_eoi(); idle(1);
    chk("R8 refire after return", int'(irq_vec_o), 21);
    tag = "R7";
    do_ack(); wr(4, 'hFF); do_eoi(); do_eoi(); do_eoi(); do_eoi();
    ev(1 << 0); idle(1);
    chk("R7 idle return ignored", int'(irq_vec_o), 16);
    wr(4, 'hFF); idle(2);

    // random phase checked against the model every cycle
    tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      if ($urandom_range(0, 3) == 0) evt_i = NSRC'($urandom);
      if (r < 10) begin
        wr_en_i = 1;
        wr_addr_i = 3'($urandom_range(0, 5));
        wr_data_i = DATA_W'($urandom);
        if (wr_addr_i == 3'd2 && $urandom_range(0, 3) != 0) wr_data_i[0] = 1'b1;
      end
      if (exp_req && $urandom_range(0, 2) == 0) ack_i = 1;
      else if ($urandom_range(0, 30) == 0) ack_i = 1;
      if ($urandom_range(0, 7) == 0) eoi_i = 1;
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule